// File: doc/BRIEF.md
# SD card clock divider

This block derives the SD card bus clock from the host clock. The ratio is a power of two. Software sets it through a 17-bit control word: a 16-bit control register plus one extension bit. The word holds four kinds of setting. An 8-bit priority-coded divide field gives ratios from 1/2 up to 1/512. A bypass select gives the undivided host clock. A high-range select gives 1/1024. A card-clock enable gates the output. The last value written can always be read back.

The block assumes a fixed software sequence: clear the enable, rewrite the divide setting, then set the enable again. Software may also change the ratio while the clock is running. In every case the block applies a change only while the card clock is low. It never emits a high or low phase shorter than half a period of the faster of the old and new clocks. A status output shows whether the card clock is actually running.

Bit positions in the control word:

| Bit(s) | Setting |
|---|---|
| 7..0 | divide field |
| 8 | enable |
| 10 | bypass |
| 16 | high range |

When several selects are set, the ratio is chosen in this order, highest priority first:

1. bypass (1/1)
2. high range (1/1024)
3. divide field equal to 0xFF (1/1, when the parameter `ALL_ONES_BYPASS` is 1)
4. highest set bit of the divide field
5. divide field all zero (1/2)

Top module: `sdclk_div`

## Requirements
- R1: When no higher-priority select applies, divide-field bit i (0 to 7) gives a card clock of the host clock divided by 2^(i+2). When several bits are set (and the field is not 0xFF), the highest set bit decides.
- R2: A divide field of 0x00, with bypass (bit 10) and high range (bit 16) clear, gives the host clock divided by 2.
- R3: With `ALL_ONES_BYPASS` = 1, a divide field of 0xFF gives the undivided host clock (1/1), as long as bit 16 is clear.
- R4: Bit 10 set gives the undivided host clock, whatever the divide field and bit 16 hold.
- R5: Bit 16 set, with bit 10 clear, gives the host clock divided by 1024, whatever the divide field holds.
- R6: While the enable (bit 8) is clear, the card clock is held low and the divider counter is held in reset. Clearing the enable stops the clock only at a low point.
- R7: A new ratio takes effect only while the card clock is low. During any change, no high or low phase is shorter than half a period of the faster of the old and new ratios. Every divided clock has a 50% duty cycle.
- R8: Reading the control word returns the last written value of bits 7..0, 8, 10 and 16. All other bits read as zero.
- R9: After reset, the control word reads 0x00080: enable clear, divide field 0x80, bypass and high range clear. The card clock is low and the running status is low.
- R10: The running status rises within a few host cycles of the enable being set. It falls within one divided period of the enable being cleared. It is never high while the card clock is held stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 17 | Control word to write |
| rd_data | output | 17 | Read-back of the control word |
| card_clk | output | 1 | SD card bus clock |
| clk_running | output | 1 | High while the card clock is running |

## Verification
The hardest situation to reach from the ports is a ratio change that lands mid-phase. This includes moves into and out of the 1/1 mode, where the output comes from the gated host clock rather than from the counter. The bench writes each new code while the clock is running, at whatever phase it happens to be in. An edge monitor then timestamps every card-clock transition and keeps the shortest phase seen during the changeover. That shortest phase is compared with half a period of the faster of the two ratios. The new period and duty cycle are measured afterwards.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int FIELD_W = 8;
    localparam int EN_POS  = 8;
    localparam int BYP_POS = 10;
    localparam int HI_POS  = 16;
    localparam int CTRL_W  = HI_POS + 1;
    localparam int MAX_LOG = FIELD_W + 2;
    localparam int LOG_W   = $clog2(MAX_LOG + 1);
    localparam int CNT_W   = MAX_LOG - 1;

    localparam logic [CTRL_W-1:0] DEF_MASK =
        CTRL_W'((1 << FIELD_W) - 1) | CTRL_W'(1 << EN_POS) |
        CTRL_W'(1 << BYP_POS) | CTRL_W'(1 << HI_POS);
    localparam logic [CTRL_W-1:0] RST_VAL = CTRL_W'(1 << (FIELD_W - 1));

    typedef logic [LOG_W-1:0] log_t;

    typedef struct packed {
        logic             run;
        logic             pass;
        logic             div;
        log_t             act;
        logic [CNT_W-1:0] cnt;
    } core_st_t;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
    import sdclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTRL_W-1:0]  wr_data,
    output logic [CTRL_W-1:0]  rd_o,
    output logic [FIELD_W-1:0] field_o,
    output logic               en_o,
    output logic               byp_o,
    output logic               hi_o
);
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) ctrl_d = wr_data & DEF_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= RST_VAL;
        else        ctrl_q <= ctrl_d;
    end

    assign rd_o    = ctrl_q;
    assign field_o = ctrl_q[FIELD_W-1:0];
    assign en_o    = ctrl_q[EN_POS];
    assign byp_o   = ctrl_q[BYP_POS];
    assign hi_o    = ctrl_q[HI_POS];
endmodule

// File: rtl/sdclk_ratio.sv
module sdclk_ratio
    import sdclk_pkg::*;
#(
    parameter bit ALL_ONES_BYPASS = 1'b1
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               byp,
    input  logic               hi,
    output log_t               lg
);
    log_t prio;
    logic all1;

    // ascending scan: the highest set bit is written last and wins
    always_comb begin
        prio = LOG_W'(1);
        for (int i = 0; i < FIELD_W; i++) begin
            if (field[i]) prio = LOG_W'(i + 2);
        end
    end

    generate
        if (ALL_ONES_BYPASS) begin : g_all1
            assign all1 = &field;
        end else begin : g_no_all1
            assign all1 = 1'b0;
        end
    endgenerate

    always_comb begin
        if (byp)       lg = '0;
        else if (hi)   lg = LOG_W'(MAX_LOG);
        else if (all1) lg = '0;
        else           lg = prio;
    end
endmodule

// File: rtl/sdclk_core.sv
module sdclk_core
    import sdclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  log_t tgt,
    output logic div_o,
    output logic pass_o,
    output logic run_o,
    output log_t act_o
);
    core_st_t st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        if (st_q.act == '0) lim = '0;
        else lim = CNT_W'((32'd1 << (32'(st_q.act) - 32'd1)) - 32'd1);
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (en) begin
                st_d.run  = 1'b1;
                st_d.act  = tgt;
                st_d.cnt  = '0;
                st_d.div  = 1'b0;
                st_d.pass = (tgt == '0);
            end
        end else if (st_q.pass) begin
            if (!en) begin
                st_d.run  = 1'b0;
                st_d.pass = 1'b0;
            end else if (tgt != '0) begin
                st_d.pass = 1'b0;
                st_d.act  = tgt;
                st_d.cnt  = '0;
                st_d.div  = 1'b0;
            end
        end else begin
            if (!en && !st_q.div) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else if (st_q.cnt == lim) begin
                st_d.cnt = '0;
                st_d.div = !st_q.div;
                if (st_q.div) begin
                    // falling point: the only place a setting is applied
                    if (!en) begin
                        st_d.run = 1'b0;
                    end else begin
                        st_d.act  = tgt;
                        st_d.pass = (tgt == '0);
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, pass: 1'b0, div: 1'b0,
                              act: LOG_W'(MAX_LOG - 1), cnt: '0};
        else        st_q <= st_d;
    end

    assign div_o  = st_q.div;
    assign pass_o = st_q.pass;
    assign run_o  = st_q.run;
    assign act_o  = st_q.act;
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_i,
    input  logic div_i,
    output logic card_clk
);
    logic pass_n_d, pass_n_q;

    always_comb pass_n_d = pass_i;

    // updated while clk is low, so the gated host clock never slivers
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) pass_n_q <= 1'b0;
        else        pass_n_q <= pass_n_d;
    end

    assign card_clk = (clk & pass_n_q) | div_i;
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
    import sdclk_pkg::*;
#(
    parameter bit ALL_ONES_BYPASS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              card_clk,
    output logic              clk_running
);
    logic [FIELD_W-1:0] field;
    logic en, byp, hi;
    log_t tgt, act;
    logic div, pass, run;

    sdclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_o(rd_data), .field_o(field), .en_o(en), .byp_o(byp), .hi_o(hi)
    );

    sdclk_ratio #(.ALL_ONES_BYPASS(ALL_ONES_BYPASS)) u_ratio (
        .field(field), .byp(byp), .hi(hi), .lg(tgt)
    );

    sdclk_core u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .tgt(tgt),
        .div_o(div), .pass_o(pass), .run_o(run), .act_o(act)
    );

    sdclk_gate u_gate (
        .clk(clk), .rst_n(rst_n), .pass_i(pass), .div_i(div),
        .card_clk(card_clk)
    );

    assign clk_running = run;
endmodule

// File: rtl/sdclk_div_chk.sv
module sdclk_div_chk
    import sdclk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] rd_data,
    input logic              div,
    input logic              pass,
    input logic              run,
    input log_t              act
);
    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!div && !pass));

    a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div, pass}));

    a_r7_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> !div);

    a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & DEF_MASK)));

    a_r10_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> (!div && !pass));
endmodule

bind sdclk_div sdclk_div_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .div(div), .pass(pass), .run(run), .act(act)
);

// File: tb/sdclk_div_test.sv
`timescale 1ns/1ps
module sdclk_div_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_data = '0;
    logic [16:0] rd_data;
    logic        card_clk;
    logic        clk_running;

    int checks = 0;
    int errors = 0;

    localparam logic [16:0] EN = 17'h00100;

    sdclk_div uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .card_clk(card_clk), .clk_running(clk_running)
    );

    always #2 clk = ~clk;

    // phase monitor
    realtime last_edge = 0.0;
    realtime min_seen = 1.0e9;
    bit      mon_on = 1'b0;
    always @(card_clk) begin
        if (mon_on && (($realtime - last_edge) < min_seen))
            min_seen = $realtime - last_edge;
        last_edge = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic real half_ns(input int k);
        return 2.0 * (2.0 ** k);
    endfunction

    task automatic meas(input int k, input string req);
        realtime t0, t1, t2;
        real exp;
        exp = 4.0 * (2.0 ** k);
        repeat (3) @(posedge card_clk);
        @(posedge card_clk) t0 = $realtime;
        @(negedge card_clk) t1 = $realtime;
        @(posedge card_clk) t2 = $realtime;
        chk((t2 - t0) > exp - 0.01 && (t2 - t0) < exp + 0.01, req, "period ns",
            t2 - t0, exp);
        chk((t1 - t0) > exp / 2 - 0.01 && (t1 - t0) < exp / 2 + 0.01, "R7",
            "high width ns", t1 - t0, exp / 2);
        chk(clk_running == 1'b1, "R10", "running while enabled", clk_running, 1);
    endtask

    task automatic stop_check(input logic [16:0] code, input int k);
        int highs;
        wr(code & ~EN);
        repeat ((1 << k) + 4) @(negedge clk);
        chk(clk_running == 1'b0, "R10", "running after stop", clk_running, 0);
        highs = 0;
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            if (card_clk) highs++;
            @(negedge clk); #1;
            if (card_clk) highs++;
        end
        chk(highs == 0, "R6", "card clock highs while disabled", highs, 0);
    endtask

    logic [16:0] cfg [15];
    int          ek  [15];
    string       rq  [15];

    initial begin
        cfg[0] = 17'h00000; ek[0] = 1; rq[0] = "R2";
        for (int i = 0; i < 8; i++) begin
            cfg[1 + i] = 17'(1 << i); ek[1 + i] = i + 2; rq[1 + i] = "R1";
        end
        cfg[9]  = 17'h00005; ek[9]  = 4;  rq[9]  = "R1";
        cfg[10] = 17'h00081; ek[10] = 9;  rq[10] = "R1";
        cfg[11] = 17'h000FF; ek[11] = 0;  rq[11] = "R3";
        cfg[12] = 17'h00480; ek[12] = 0;  rq[12] = "R4";
        cfg[13] = 17'h10403; ek[13] = 0;  rq[13] = "R4";
        cfg[14] = 17'h10040; ek[14] = 10; rq[14] = "R5";
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(rd_data == 17'h00080, "R9", "reset rd_data", rd_data, 17'h00080);
        chk(clk_running == 1'b0, "R9", "reset running", clk_running, 0);
        chk(card_clk == 1'b0, "R9", "reset card_clk", card_clk, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(card_clk == 1'b0 && clk_running == 1'b0, "R9", "idle after reset",
            card_clk, 0);

        // R8 masking of undefined bits, enable clear keeps clock stopped
        wr(17'h1FEFF);
        @(negedge clk);
        chk(rd_data == 17'h104FF, "R8", "masked read-back", rd_data, 17'h104FF);
        repeat (8) @(negedge clk);
        chk(clk_running == 1'b0, "R6", "no run with enable clear", clk_running, 0);

        // sweep of every divide encoding
        for (int c = 0; c < 15; c++) begin
            wr(cfg[c]);
            wr(cfg[c] | EN);
            @(negedge clk);
            chk(rd_data == (cfg[c] | EN), "R8", "read-back", rd_data, cfg[c] | EN);
            meas(ek[c], rq[c]);
            stop_check(cfg[c], ek[c]);
        end

        // live ratio changes
        begin
            logic [16:0] fa [6];
            logic [16:0] fb [6];
            int ka [6];
            int kb [6];
            fa[0] = 17'h00000; ka[0] = 1; fb[0] = 17'h00080; kb[0] = 9;
            fa[1] = 17'h00080; ka[1] = 9; fb[1] = 17'h00000; kb[1] = 1;
            fa[2] = 17'h000FF; ka[2] = 0; fb[2] = 17'h00002; kb[2] = 3;
            fa[3] = 17'h00002; ka[3] = 3; fb[3] = 17'h000FF; kb[3] = 0;
            fa[4] = 17'h00400; ka[4] = 0; fb[4] = 17'h10000; kb[4] = 10;
            fa[5] = 17'h00008; ka[5] = 5; fb[5] = 17'h00400; kb[5] = 0;
            for (int t = 0; t < 6; t++) begin
                real lim;
                wr(fa[t]);
                wr(fa[t] | EN);
                meas(ka[t], "R7");
                repeat (t * 3 + 1) @(negedge clk);
                min_seen = 1.0e9;
                mon_on = 1'b1;
                wr(fb[t] | EN);
                meas(kb[t], "R7");
                mon_on = 1'b0;
                lim = (half_ns(ka[t]) < half_ns(kb[t])) ? half_ns(ka[t]) : half_ns(kb[t]);
                chk(min_seen > lim - 0.01, "R7", "shortest phase in change ns",
                    min_seen, lim);
                stop_check(fb[t], kb[t]);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule